// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This unit holds a 64-bit command that a processor assembles to send an interrupt to other processors. The command is split into two 32-bit words on a plain memory-mapped register bus. The high word holds the target identifier. The low word holds the vector, the delivery mode, the trigger and level bits and a destination shorthand.

Software writes the high word first and then the low word. Only the low-word write sends anything. At that point the unit takes a snapshot of the complete message and presents it on a valid/ready message output. A busy bit in the low word stays set until the downstream port accepts the message. Software polls that bit before it issues the next command.

When the shorthand field is non-zero, it replaces the target identifier from the high word. A low-word write that arrives while a message is still pending is dropped, and it sets a sticky error flag.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `msg_valid` and `send_err` are 0, and both command words read back as 0.
- R2: A write to offset 0x310 stores bits [31:24] as the target identifier. A read of 0x310 returns that identifier in [31:24] and zero in every other bit.
- R3: A low-word write at 0x300 while idle stores the following fields:
  - vector in [7:0]
  - delivery mode in [10:8]
  - level in bit 14 (1 asserts, 0 deasserts)
  - trigger in bit 15 (1 for level)
  - shorthand in [19:18]

  A read of 0x300 returns these fields in place. The remote-read status field [17:16] reads 00 (invalid), and every other bit outside the fields and the busy bit reads 0.
- R4: An accepted low-word write sets `msg_valid` and the busy bit (bit 12 of 0x300) in the cycle after the write edge.
- R5: The message output carries the vector, mode, trigger, level and shorthand of the accepted low-word write.
- R6: The destination of the message depends on the shorthand:
  - shorthand 00 (use field): the stored high-word identifier
  - shorthand 01 (self): `local_id`
  - shorthand 10 (all including self): 8'hFF
  - shorthand 11 (all excluding self): 8'hFF
- R7: `msg_valid` and the whole payload stay unchanged while `msg_ready` is low. At the first edge where `msg_valid` and `msg_ready` are both high, `msg_valid` and the busy bit clear. The stored command fields stay unchanged.
- R8: A low-word write while busy is ignored: the pending message and the stored low-word fields are unchanged. Such a write sets `send_err`, which stays set until reset.
- R9: A high-word write never launches a message. A high-word write during a pending message leaves that message's destination unchanged.
- R10: Writes to any offset other than 0x300 and 0x310 change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| local_id | input | 8 | Identifier of this processor, used by the self shorthand |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Resolved destination identifier |
| msg_short | output | 2 | Destination shorthand |
| msg_mode | output | 3 | Delivery mode |
| msg_trig | output | 1 | Trigger mode, 1 for level |
| msg_level | output | 1 | Level, 1 asserts |
| msg_vector | output | 8 | Interrupt vector |
| send_err | output | 1 | Sticky flag: a low-word write arrived while busy |

## Verification
Read data is combinational, so a register read is sampled 1 ns after the address is driven on a falling edge. `msg_valid`, the payload and the busy bit pass through one register. They are sampled at the falling edge that follows the write edge. A handshake clears busy at the next rising edge, so the bench raises `msg_ready` at a falling edge and checks the cleared state at the following falling edge. The sweep covers every shorthand, delivery mode, trigger and level combination, with an acceptance delay of 0 to 2 cycles that varies across the sweep. The bench checks the payload in every cycle while the message waits.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  localparam int ID_W  = 8;
  localparam int VEC_W = 8;
  localparam int MD_W  = 3;
  localparam int SH_W  = 2;
  localparam int BUSY_BIT = 12;
  localparam logic [ID_W-1:0] BCAST_ID = '1;

  typedef enum logic [SH_W-1:0] {
    SH_FIELD  = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALLINC = 2'b10,
    SH_ALLEXC = 2'b11
  } ipi_short_e;

  typedef struct packed {
    logic [SH_W-1:0]  shorthand;
    logic             trig;
    logic             level;
    logic [MD_W-1:0]  mode;
    logic [VEC_W-1:0] vector;
  } ipi_lo_t;

  function automatic ipi_lo_t lo_unpack(input logic [31:0] w);
    ipi_lo_t f;
    f.vector    = w[7:0];
    f.mode      = w[10:8];
    f.level     = w[14];
    f.trig      = w[15];
    f.shorthand = w[19:18];
    return f;
  endfunction

  function automatic logic [31:0] lo_pack(input ipi_lo_t f, input logic busy);
    logic [31:0] w;
    w = '0;
    w[7:0]      = f.vector;
    w[10:8]     = f.mode;
    w[BUSY_BIT] = busy;
    w[14]       = f.level;
    w[15]       = f.trig;
    w[17:16]    = 2'b00;
    w[19:18]    = f.shorthand;
    return w;
  endfunction

  function automatic logic [ID_W-1:0] dest_resolve(input logic [SH_W-1:0] sh,
                                                   input logic [ID_W-1:0] field_id,
                                                   input logic [ID_W-1:0] self_id);
    case (ipi_short_e'(sh))
      SH_FIELD: return field_id;
      SH_SELF:  return self_id;
      default:  return BCAST_ID;
    endcase
  endfunction
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              lo_sel,
  output logic              hi_sel,
  output logic              lo_wr,
  output logic              hi_wr
);
  always_comb begin
    lo_sel = (bus_addr == LO_OFF);
    hi_sel = (bus_addr == HI_OFF);
    lo_wr  = bus_wr && lo_sel;
    hi_wr  = bus_wr && hi_sel;
  end
endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_wr,
  input  logic [ID_W-1:0] hi_wdata,
  input  logic            lo_take,
  input  ipi_lo_t         lo_wdata,
  output logic [ID_W-1:0] hi_q,
  output ipi_lo_t         lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_wr)   hi_q <= hi_wdata;
      if (lo_take) lo_q <= lo_wdata;
    end
  end
endmodule

// File: rtl/ipi_cmd_launch.sv
module ipi_cmd_launch
  import ipi_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_wr,
  input  ipi_lo_t         lo_wdata,
  input  logic [ID_W-1:0] hi_id,
  input  logic [ID_W-1:0] local_id,
  input  logic            msg_ready,
  output logic            lo_take,
  output logic            hand_evt,
  output logic            busy,
  output logic            send_err,
  output ipi_lo_t         msg_f,
  output logic [ID_W-1:0] msg_dest
);
  logic drop_evt;

  always_comb begin
    lo_take  = lo_wr && !busy;
    drop_evt = lo_wr && busy;
    hand_evt = busy && msg_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      send_err <= 1'b0;
      msg_f    <= '0;
      msg_dest <= '0;
    end else begin
      if (drop_evt) send_err <= 1'b1;
      if (lo_take) begin
        busy     <= 1'b1;
        msg_f    <= lo_wdata;
        msg_dest <= dest_resolve(lo_wdata.shorthand, hi_id, local_id);
      end else if (hand_evt) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [ID_W-1:0]   local_id,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ID_W-1:0]   msg_dest,
  output logic [SH_W-1:0]   msg_short,
  output logic [MD_W-1:0]   msg_mode,
  output logic              msg_trig,
  output logic              msg_level,
  output logic [VEC_W-1:0]  msg_vector,
  output logic              send_err
);
  logic            lo_sel, hi_sel, lo_wr, hi_wr;
  logic            lo_take, hand_evt, busy;
  logic [ID_W-1:0] hi_q;
  ipi_lo_t         lo_q, lo_in, msg_f;
  logic            unused_wbits;

  assign lo_in        = lo_unpack(bus_wdata);
  assign unused_wbits = ^{bus_wdata[23:20], bus_wdata[17:16], bus_wdata[13:11]};

  ipi_cmd_decode #(.ADDR_W(ADDR_W), .LO_OFF(LO_OFF), .HI_OFF(HI_OFF)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr),
    .lo_sel(lo_sel), .hi_sel(hi_sel), .lo_wr(lo_wr), .hi_wr(hi_wr)
  );

  ipi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .hi_wr(hi_wr), .hi_wdata(bus_wdata[31:24]),
    .lo_take(lo_take), .lo_wdata(lo_in),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  ipi_cmd_launch u_launch (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(lo_wr), .lo_wdata(lo_in), .hi_id(hi_q), .local_id(local_id),
    .msg_ready(msg_ready),
    .lo_take(lo_take), .hand_evt(hand_evt), .busy(busy), .send_err(send_err),
    .msg_f(msg_f), .msg_dest(msg_dest)
  );

  always_comb begin
    bus_rdata = '0;
    if (lo_sel)      bus_rdata = lo_pack(lo_q, busy);
    else if (hi_sel) bus_rdata = {hi_q, 24'h0};
  end

  assign msg_valid  = busy;
  assign msg_short  = msg_f.shorthand;
  assign msg_mode   = msg_f.mode;
  assign msg_trig   = msg_f.trig;
  assign msg_level  = msg_f.level;
  assign msg_vector = msg_f.vector;
endmodule

// File: rtl/ipi_cmd_chk.sv
module ipi_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lo_wr,
  input logic       hi_wr,
  input logic       lo_take,
  input logic       msg_valid,
  input logic       msg_ready,
  input logic [7:0] msg_dest,
  input logic [1:0] msg_short,
  input logic [2:0] msg_mode,
  input logic       msg_trig,
  input logic       msg_level,
  input logic [7:0] msg_vector,
  input logic       send_err
);
  AST_LAUNCH_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(lo_wr)); // R4

  AST_HI_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr && !msg_valid) |=> !msg_valid); // R9

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid &&
      $stable({msg_dest, msg_short, msg_mode, msg_trig, msg_level, msg_vector}))); // R7

  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && !lo_take) |=> !msg_valid); // R7

  AST_BCAST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short[1]) |-> (msg_dest == 8'hFF)); // R6

  AST_ERR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && lo_wr) |=> send_err); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    send_err |=> send_err); // R8
endmodule

bind ipi_cmd_unit ipi_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .lo_take(lo_take),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
  .msg_short(msg_short), .msg_mode(msg_mode), .msg_trig(msg_trig),
  .msg_level(msg_level), .msg_vector(msg_vector), .send_err(send_err)
);

// File: tb/test_ipi_cmd_unit.sv
module test_ipi_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  local_id = 8'h2A;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_dest, msg_vector;
  logic [1:0]  msg_short;
  logic [2:0]  msg_mode;
  logic        msg_trig, msg_level, send_err;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [11:0] A_LO = 12'h300;
  localparam logic [11:0] A_HI = 12'h310;
  localparam logic [31:0] JUNK = 32'hFFF3_2800;

  always #2 clk = ~clk;

  ipi_cmd_unit i_ipi_cmd_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .local_id(local_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_short(msg_short), .msg_mode(msg_mode), .msg_trig(msg_trig),
    .msg_level(msg_level), .msg_vector(msg_vector), .send_err(send_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] lo_word(input int sh, input int md, input int tr,
                                          input int lv, input int vec, input int bsy);
    return 32'((sh << 18) + (tr << 15) + (lv << 14) + (bsy << 12) + (md << 8) + vec);
  endfunction

  function automatic logic [7:0] exp_dest(input int sh, input logic [7:0] fld);
    if (sh == 0) return fld;
    if (sh == 1) return local_id;
    return 8'hFF;
  endfunction

  task automatic chk_msg(input string req, input logic [7:0] d, input int sh,
                         input int md, input int tr, input int lv, input int vec);
    logic [31:0] act, exp;
    act = {7'b0, msg_valid, msg_dest, msg_short, msg_mode, msg_trig, msg_level, msg_vector};
    exp = {7'b0, 1'b1, d, 2'(sh), 3'(md), 1'(tr), 1'(lv), 8'(vec)};
    check(act == exp, req, act, exp);
  endtask

  task automatic check_reset_state();
    logic [31:0] r;
    check(msg_valid == 1'b0, "R1 valid", 32'(msg_valid), 0);
    check(send_err == 1'b0, "R1 err", 32'(send_err), 0);
    rd(A_LO, r); check(r == 0, "R1 low", r, 0);
    rd(A_HI, r); check(r == 0, "R1 high", r, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] fd;
    int sh, md, tr, lv, vec, idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // R10: stray offset
    wr(12'h320, 32'hFFFF_FFFF);
    rd(12'h320, r); check(r == 0, "R10 read", r, 0);
    rd(A_LO, r); check(r == 0, "R10 low untouched", r, 0);
    rd(A_HI, r); check(r == 0, "R10 high untouched", r, 0);
    check(msg_valid == 0, "R10 no launch", 32'(msg_valid), 0);

    // sweep of shorthand, mode, trigger, level
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int t = 0; t < 4; t++) begin
          sh = s; md = m; tr = t >> 1; lv = t & 1;
          idx = s * 32 + m * 4 + t;
          vec = (s * 37 + m * 11 + t * 71 + 5) % 256;
          fd = 8'((idx * 5 + 3) % 256);
          wr(A_HI, {fd, 24'hABCDEF});
          rd(A_HI, r); check(r == {fd, 24'h0}, "R2 high readback", r, {fd, 24'h0});
          check(msg_valid == 0, "R9 high write no launch", 32'(msg_valid), 0);
          wr(A_LO, lo_word(sh, md, tr, lv, vec, 0) | JUNK);
          chk_msg("R4 R5 R6 launch", exp_dest(sh, fd), sh, md, tr, lv, vec);
          rd(A_LO, r);
          check(r == lo_word(sh, md, tr, lv, vec, 1), "R3 R4 low readback busy", r,
                lo_word(sh, md, tr, lv, vec, 1));
          for (int k = 0; k < idx % 3; k++) begin
            @(negedge clk);
            chk_msg("R7 hold", exp_dest(sh, fd), sh, md, tr, lv, vec);
          end
          @(negedge clk); msg_ready = 1'b1;
          @(negedge clk); msg_ready = 1'b0;
          check(msg_valid == 0, "R7 cleared", 32'(msg_valid), 0);
          rd(A_LO, r);
          check(r == lo_word(sh, md, tr, lv, vec, 0), "R7 busy clear readback", r,
                lo_word(sh, md, tr, lv, vec, 0));
        end
      end
    end
    check(send_err == 0, "R8 no error in sweep", 32'(send_err), 0);

    // R8 / R9: writes while busy
    wr(A_HI, 32'h1100_0000);
    wr(A_LO, lo_word(0, 5, 1, 1, 8'h40, 0));
    chk_msg("R6 field dest", 8'h11, 0, 5, 1, 1, 8'h40);
    wr(A_HI, 32'h7700_0000);
    chk_msg("R9 high write during busy", 8'h11, 0, 5, 1, 1, 8'h40);
    rd(A_HI, r); check(r == 32'h7700_0000, "R2 high updates while busy", r, 32'h7700_0000);
    wr(A_LO, lo_word(2, 2, 0, 0, 8'h99, 0));
    chk_msg("R8 busy write ignored", 8'h11, 0, 5, 1, 1, 8'h40);
    check(send_err == 1, "R8 err set", 32'(send_err), 1);
    rd(A_LO, r);
    check(r == lo_word(0, 5, 1, 1, 8'h40, 1), "R8 low unchanged", r, lo_word(0, 5, 1, 1, 8'h40, 1));
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
    wr(A_LO, lo_word(1, 0, 0, 1, 8'h22, 0));
    chk_msg("R6 self dest", local_id, 1, 0, 0, 1, 8'h22);
    check(send_err == 1, "R8 err sticky", 32'(send_err), 1);
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;

    // R1: reset clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule